// File: doc/BRIEF.md
# Flit-Path Test Cell with Bypass

This block sits on one port of a router and carries 34-bit flits over valid/ready handshakes. It has a network side (`noc_in`, `noc_out`), a test side (`cell_in`, `cell_out`) and a bypass side. A first selection stage decides which source feeds `noc_out`: the network flit, a test flit injected on `cell_in`, or, in the output-cell variant, a flit arriving on `byp_in`. A destination stage forks the incoming network flit towards the forward path, the observation port `cell_out`, or, in the input-cell variant, the bypass output `byp_out`.

At a fork the data appears on every branch at once. Only the branch that has been selected raises its valid. The upstream ready is taken from that branch alone, so a branch that is not used can never hold up the stream. The bypass pair lets a router that has already been tested be skipped: an input cell sends link traffic out on `byp_out`, and the matching output cell takes it in on `byp_in`. An optional register on the forward path adds one cycle of latency and keeps full throughput. A parameter chooses the input or output variant.

Top module: `flit_test_cell`

## Requirements
- R1: With source code 0 (network) and destination code 0 (forward), a flit accepted on `noc_in` appears unchanged on `noc_out` one clock edge later (with the default register stage), and `cell_out_valid` stays low.
- R2: With `noc_out_ready` held high, the forward path accepts and delivers one flit on every clock cycle.
- R3: While `noc_out_valid` is high and `noc_out_ready` is low, `noc_out_data` stays stable and the forward path does not accept a new flit.
- R4: The `src_sel` codes are 0 = network flit, 1 = `cell_in`, 2 = `byp_in` (output variant only). Code 3, and code 2 in the input variant, leave `noc_out` idle.
- R5: The `dst_sel` codes for the network flit are 0 = forward to `noc_out`, 1 = `cell_out`, 2 = `byp_out` (input variant only). Code 3, and code 2 in the output variant, keep `noc_in_ready` low.
- R6: Only the selected destination branch asserts valid, with `noc_in_data` on its data port. `noc_in_ready` equals the ready of the selected sink, and the readies of the other sinks have no effect on it.
- R7: A source that `src_sel` does not select sees its ready held low.
- R8: With destination 0 and a source other than the network, `noc_in_ready` is low.
- R9: After reset, `noc_out_valid` is low.
- R10: In the input variant (VARIANT=0) `byp_in_ready` is always low. In the output variant (VARIANT=1) `byp_out_valid` is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Source code for the forward path (R4) |
| dst_sel | input | 2 | Destination code for the network flit (R5) |
| noc_in_valid | input | 1 | Network flit valid |
| noc_in_ready | output | 1 | Network flit accepted |
| noc_in_data | input | 34 | Network flit |
| noc_out_valid | output | 1 | Flit towards the router or link |
| noc_out_ready | input | 1 | Downstream ready |
| noc_out_data | output | 34 | Outgoing flit |
| cell_in_valid | input | 1 | Test flit valid |
| cell_in_ready | output | 1 | Test flit accepted |
| cell_in_data | input | 34 | Injected test flit |
| cell_out_valid | output | 1 | Observed flit valid |
| cell_out_ready | input | 1 | Observer ready |
| cell_out_data | output | 34 | Observed flit |
| byp_in_valid | input | 1 | Bypass flit valid (output variant) |
| byp_in_ready | output | 1 | Bypass flit accepted |
| byp_in_data | input | 34 | Bypass flit in |
| byp_out_valid | output | 1 | Bypass flit valid (input variant) |
| byp_out_ready | input | 1 | Bypass receiver ready |
| byp_out_data | output | 34 | Bypass flit out |

## Verification
The hardest situation to reach is a conflict between the two selection stages: the network flit is sent forward while the forward path takes its data from another source. The network flit must then stall and must not leak through. Ordinary traffic never produces this case. The bench sets it up on purpose by driving every source valid together with the conflicting codes, in both variants, and with the ready of every unselected sink set to the opposite of what the selected one needs. A directed backpressure sequence fills the output register and then holds it, so that the stability rule and the full-rate refill are both exercised.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
   typedef enum logic [1:0] {
      SRC_NET  = 2'd0,
      SRC_TEST = 2'd1,
      SRC_BYP  = 2'd2,
      SRC_OFF  = 2'd3
   } src_e;

   typedef enum logic [1:0] {
      DST_FWD  = 2'd0,
      DST_OBS  = 2'd1,
      DST_BYP  = 2'd2,
      DST_OFF  = 2'd3
   } dst_e;

   localparam int unsigned VARIANT_IN  = 0;
   localparam int unsigned VARIANT_OUT = 1;
endpackage

// File: rtl/ftc_fork.sv
module ftc_fork
   import ftc_pkg::*;
#(
   parameter bit HAS_BYP = 1'b1
) (
   input  dst_e dst,
   input  logic in_valid,
   output logic in_ready,
   output logic fwd_valid,
   input  logic fwd_ready,
   output logic obs_valid,
   input  logic obs_ready,
   output logic byp_valid,
   input  logic byp_ready
);
   logic sel_fwd, sel_obs, sel_byp;

   assign sel_fwd = (dst == DST_FWD);
   assign sel_obs = (dst == DST_OBS);
   assign sel_byp = HAS_BYP && (dst == DST_BYP);

   // data goes to every branch; valid only to the chosen one
   assign fwd_valid = in_valid & sel_fwd;
   assign obs_valid = in_valid & sel_obs;
   assign byp_valid = in_valid & sel_byp;

   assign in_ready = (sel_fwd & fwd_ready) | (sel_obs & obs_ready) | (sel_byp & byp_ready);
endmodule

// File: rtl/ftc_srcsel.sv
module ftc_srcsel
   import ftc_pkg::*;
#(
   parameter int unsigned W       = 34,
   parameter bit          HAS_BYP = 1'b0
) (
   input  src_e           src,
   input  logic           net_valid,
   output logic           net_ready,
   input  logic [W-1:0]   net_data,
   input  logic           test_valid,
   output logic           test_ready,
   input  logic [W-1:0]   test_data,
   input  logic           byp_valid,
   output logic           byp_ready,
   input  logic [W-1:0]   byp_data,
   output logic           out_valid,
   input  logic           out_ready,
   output logic [W-1:0]   out_data
);
   always_comb begin
      out_valid  = 1'b0;
      out_data   = net_data;
      net_ready  = 1'b0;
      test_ready = 1'b0;
      byp_ready  = 1'b0;
      case (src)
         SRC_NET: begin
            out_valid = net_valid;
            net_ready = out_ready;
         end
         SRC_TEST: begin
            out_valid  = test_valid;
            out_data   = test_data;
            test_ready = out_ready;
         end
         SRC_BYP: begin
            if (HAS_BYP) begin
               out_valid = byp_valid;
               out_data  = byp_data;
               byp_ready = out_ready;
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/ftc_stage.sv
module ftc_stage #(
   parameter int unsigned W  = 34,
   parameter bit          EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   generate
      if (EN) begin : g_reg
         logic         v_q;
         logic [W-1:0] d_q;

         assign in_ready = !v_q || out_ready;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               d_q <= '0;
            end else if (in_ready) begin
               v_q <= in_valid;
               d_q <= in_data;
            end
         end

         assign out_valid = v_q;
         assign out_data  = d_q;

         // R3: a held flit stays put until taken
         p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
         // R3: no new flit accepted while full and stalled
         p_no_accept_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_ready) |-> !in_ready);
      end else begin : g_wire
         assign in_ready  = out_ready;
         assign out_valid = in_valid;
         assign out_data  = in_data;
      end
   endgenerate
endmodule

// File: rtl/flit_test_cell.sv
module flit_test_cell
   import ftc_pkg::*;
#(
   parameter int unsigned W         = 34,
   parameter int unsigned VARIANT   = VARIANT_IN,
   parameter bit          OUT_STAGE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   src_sel,
   input  logic [1:0]   dst_sel,
   input  logic         noc_in_valid,
   output logic         noc_in_ready,
   input  logic [W-1:0] noc_in_data,
   output logic         noc_out_valid,
   input  logic         noc_out_ready,
   output logic [W-1:0] noc_out_data,
   input  logic         cell_in_valid,
   output logic         cell_in_ready,
   input  logic [W-1:0] cell_in_data,
   output logic         cell_out_valid,
   input  logic         cell_out_ready,
   output logic [W-1:0] cell_out_data,
   input  logic         byp_in_valid,
   output logic         byp_in_ready,
   input  logic [W-1:0] byp_in_data,
   output logic         byp_out_valid,
   input  logic         byp_out_ready,
   output logic [W-1:0] byp_out_data
);
   localparam bit FORK_BYP = (VARIANT == VARIANT_IN);
   localparam bit SRC_BYP_EN = (VARIANT == VARIANT_OUT);

   generate
      if (W < 1) begin : g_bad_w
         $error("flit_test_cell: W must be at least 1");
      end
      if (VARIANT > 1) begin : g_bad_var
         $error("flit_test_cell: VARIANT must be 0 or 1");
      end
   endgenerate

   src_e src;
   dst_e dst;
   assign src = src_e'(src_sel);
   assign dst = dst_e'(dst_sel);

   logic         net_fwd_valid, net_fwd_ready;
   logic         mux_valid, mux_ready;
   logic [W-1:0] mux_data;

   ftc_fork #(.HAS_BYP(FORK_BYP)) u_fork (
      .dst       (dst),
      .in_valid  (noc_in_valid),
      .in_ready  (noc_in_ready),
      .fwd_valid (net_fwd_valid),
      .fwd_ready (net_fwd_ready),
      .obs_valid (cell_out_valid),
      .obs_ready (cell_out_ready),
      .byp_valid (byp_out_valid),
      .byp_ready (byp_out_ready)
   );

   assign cell_out_data = noc_in_data;
   assign byp_out_data  = noc_in_data;

   ftc_srcsel #(.W(W), .HAS_BYP(SRC_BYP_EN)) u_src (
      .src        (src),
      .net_valid  (net_fwd_valid),
      .net_ready  (net_fwd_ready),
      .net_data   (noc_in_data),
      .test_valid (cell_in_valid),
      .test_ready (cell_in_ready),
      .test_data  (cell_in_data),
      .byp_valid  (byp_in_valid),
      .byp_ready  (byp_in_ready),
      .byp_data   (byp_in_data),
      .out_valid  (mux_valid),
      .out_ready  (mux_ready),
      .out_data   (mux_data)
   );

   ftc_stage #(.W(W), .EN(OUT_STAGE)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (mux_valid),
      .in_ready  (mux_ready),
      .in_data   (mux_data),
      .out_valid (noc_out_valid),
      .out_ready (noc_out_ready),
      .out_data  (noc_out_data)
   );

   // R1: plain network mode never shows a flit on the observation port
   p_normal_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel == SRC_NET && dst_sel == DST_FWD) |-> !cell_out_valid);
   // R6: an observation branch takes its ready from the observer alone
   p_obs_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_sel == DST_OBS) |-> (noc_in_ready == cell_out_ready));
   // R6: at most one destination branch is valid
   p_one_branch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cell_out_valid, byp_out_valid}));
   // R7: an unselected test source is never acknowledged
   p_test_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel != SRC_TEST) |-> !cell_in_ready);
   // R8: forward destination with a foreign source stalls the network flit
   p_conflict_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_sel == DST_FWD && src_sel != SRC_NET) |-> !noc_in_ready);

   generate
      if (VARIANT == VARIANT_IN) begin : g_chk_in
         // R10: input variant has no bypass input
         p_no_byp_in_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !byp_in_ready);
      end else begin : g_chk_out
         // R10: output variant has no bypass output
         p_no_byp_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !byp_out_valid);
      end
   endgenerate
endmodule

// File: tb/flit_test_cell_tb.sv
`timescale 1ns/1ps
module flit_test_cell_tb;
   localparam int W = 34;
   localparam logic [W-1:0] D_NET  = 34'h2_5A5A_0001;
   localparam logic [W-1:0] D_TEST = 34'h1_C3C3_0002;
   localparam logic [W-1:0] D_BYP  = 34'h3_0F0F_0003;

   // fields: var | src | dst | niv civ biv cor bor | nir cir bir cov bov | nos
   localparam int NV = 13;
   localparam logic [16:0] VEC [NV] = '{
      17'b0_00_00_11111_10000_01,  // R1 normal, input variant
      17'b1_00_00_11111_10000_01,  // R1 normal, output variant
      17'b0_01_01_11101_01010_10,  // R6 observer stalled, inject
      17'b0_01_01_11110_11010_10,  // R6 observer ready, bypass sink not
      17'b0_00_10_11110_00001_00,  // R5 bypass out, receiver stalled
      17'b0_00_10_10001_10001_00,  // R5 bypass out, receiver ready
      17'b1_10_00_11111_00100_11,  // R4 R8 bypass in source
      17'b1_10_01_10111_10110_11,  // R4 bypass in plus observation
      17'b1_00_10_11111_00000_00,  // R5 reserved dst in output variant
      17'b0_10_00_11111_00000_00,  // R4 reserved src in input variant
      17'b0_01_11_00111_01000_00,  // R5 dst off, test idle
      17'b1_01_00_01011_01000_10,  // R7 R8 test inject
      17'b0_00_00_01111_10000_00   // R1 idle
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [1:0]   src_sel = '0, dst_sel = '0;
   logic         niv = 1'b0, civ = 1'b0, biv = 1'b0;
   logic         nor_r = 1'b1, cor = 1'b0, bor = 1'b0;
   logic [W-1:0] nid = D_NET, cid = D_TEST, bid = D_BYP;

   logic         i_nir, i_nov, i_cir, i_cov, i_bir, i_bov;
   logic [W-1:0] i_nod, i_cod, i_bod;
   logic         o_nir, o_nov, o_cir, o_cov, o_bir, o_bov;
   logic [W-1:0] o_nod, o_cod, o_bod;

   flit_test_cell #(.W(W), .VARIANT(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .dst_sel(dst_sel),
      .noc_in_valid(niv), .noc_in_ready(i_nir), .noc_in_data(nid),
      .noc_out_valid(i_nov), .noc_out_ready(nor_r), .noc_out_data(i_nod),
      .cell_in_valid(civ), .cell_in_ready(i_cir), .cell_in_data(cid),
      .cell_out_valid(i_cov), .cell_out_ready(cor), .cell_out_data(i_cod),
      .byp_in_valid(biv), .byp_in_ready(i_bir), .byp_in_data(bid),
      .byp_out_valid(i_bov), .byp_out_ready(bor), .byp_out_data(i_bod));

   flit_test_cell #(.W(W), .VARIANT(1)) u_dut_o (
      .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .dst_sel(dst_sel),
      .noc_in_valid(niv), .noc_in_ready(o_nir), .noc_in_data(nid),
      .noc_out_valid(o_nov), .noc_out_ready(nor_r), .noc_out_data(o_nod),
      .cell_in_valid(civ), .cell_in_ready(o_cir), .cell_in_data(cid),
      .cell_out_valid(o_cov), .cell_out_ready(cor), .cell_out_data(o_cod),
      .byp_in_valid(biv), .byp_in_ready(o_bir), .byp_in_data(bid),
      .byp_out_valid(o_bov), .byp_out_ready(bor), .byp_out_data(o_bod));

   int checks = 0;
   int errors = 0;

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] src_data(input logic [1:0] code);
      case (code)
         2'd1: return D_NET;
         2'd2: return D_TEST;
         default: return D_BYP;
      endcase
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 reset noc_out_valid in", {33'b0, i_nov}, '0);
      chk("R9 reset noc_out_valid out", {33'b0, o_nov}, '0);

      for (int k = 0; k < NV; k++) begin
         logic v;
         logic [16:0] e;
         e = VEC[k];
         v = e[16];
         src_sel = e[15:14]; dst_sel = e[13:12];
         niv = e[11]; civ = e[10]; biv = e[9]; cor = e[8]; bor = e[7];
         nor_r = 1'b1;
         #1;
         chk("R5 R6 R8 noc_in_ready", {33'b0, v ? o_nir : i_nir}, {33'b0, e[6]});
         chk("R7 cell_in_ready",      {33'b0, v ? o_cir : i_cir}, {33'b0, e[5]});
         chk("R7 R10 byp_in_ready",   {33'b0, v ? o_bir : i_bir}, {33'b0, e[4]});
         chk("R1 R6 cell_out_valid",  {33'b0, v ? o_cov : i_cov}, {33'b0, e[3]});
         chk("R10 byp_out_valid",     {33'b0, v ? o_bov : i_bov}, {33'b0, e[2]});
         if (e[3]) chk("R6 cell_out_data", v ? o_cod : i_cod, D_NET);
         if (e[2]) chk("R6 byp_out_data", i_bod, D_NET);
         @(negedge clk);
         chk("R4 noc_out_valid", {33'b0, v ? o_nov : i_nov}, {33'b0, (e[1:0] != 2'd0)});
         if (e[1:0] != 2'd0)
            chk("R4 noc_out_data", v ? o_nod : i_nod, src_data(e[1:0]));
      end

      // R3: fill the register, then stall it
      src_sel = 2'd0; dst_sel = 2'd0; civ = 1'b0; biv = 1'b0;
      niv = 1'b1; nid = 34'h0_1111_0001; nor_r = 1'b0;
      @(negedge clk);
      chk("R1 noc_out_valid latency", {33'b0, i_nov}, 34'd1);
      chk("R1 noc_out_data latency", i_nod, 34'h0_1111_0001);
      chk("R3 noc_in_ready while full", {33'b0, i_nir}, '0);
      nid = 34'h0_2222_0002;
      @(negedge clk);
      chk("R3 held data", i_nod, 34'h0_1111_0001);
      chk("R3 held valid", {33'b0, i_nov}, 34'd1);

      // R2: back-to-back stream
      nor_r = 1'b1;
      for (int s = 0; s < 4; s++) begin
         logic [W-1:0] f;
         f = 34'h0_3000_0000 + W'(s);
         nid = f;
         #1;
         chk("R2 noc_in_ready streaming", {33'b0, i_nir}, 34'd1);
         @(negedge clk);
         chk("R2 noc_out_data streaming", i_nod, f);
      end
      niv = 1'b0;
      @(negedge clk);
      chk("R2 drained", {33'b0, i_nov}, '0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule